// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Sensing

This block is a memory-mapped general-purpose I/O controller serving three banks of 32 pins. Software reaches it through a plain single-cycle register bus with 32-bit words. Each pin can be switched between input and output, driven high or low through write-one set and clear registers, optionally inverted before sensing, and armed to latch interrupts on any mix of rising edge, falling edge, high level and low level.

Registers are grouped by function. Each group occupies 16 bytes, and inside a group the banks sit one word apart. Pin inputs pass through a synchroniser before anything reads them. Sensed events latch into per-bank status words that software clears one bit at a time. A per-pin record shows whether an edge caused the latch. The status bits of all banks merge into one shared interrupt output.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset the direction, polarity, output data, all four sense-enable, status and edge-record words read 0 in every bank, `pin_oe` is all zero and `irq` is low.
- R2: The register address is group offset plus 4 × bank, with groups direction 0x00, polarity 0x10, data 0x20, set 0x30, clear 0x40, rising 0x50, falling 0x60, high-level 0x70, low-level 0x80, status 0x90 and edge record 0xA0. Global pin p is bank p/32, bit p%32. An access with `bus_addr[1:0]` not 00 does nothing and reads 0.
- R3: A direction bit of 1 drives `pin_oe` high and `pin_out` with the output data bit. Reading data returns the output data bit for output pins. For input pins it returns `pin_in` two clocks later.
- R4: Writing 1s to the set word raises those output data bits. Writing 1s to the clear word lowers them. Bits written 0 are untouched. Both words read 0. The edge-record word ignores writes.
- R5: A polarity bit of 1 inverts that pin's synchronised input before edge and level sensing.
- R6: An enabled rising or falling edge sets the pin's status bit on the third clock after `pin_in` changes. Both edges may be enabled together. An edge latches once and does not re-set after a clear.
- R7: An enabled high or low level sets the status bit on every clock while it persists, so the bit returns after a clear.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. A clear in the same cycle as a new event for that pin leaves the bit set.
- R9: An edge-record bit reads 1 once an edge has been latched for that pin. It stays 0 for level-only latches and clears with its status bit.
- R10: `irq` is high exactly while any status bit of any bank is set.
- R11: A pin whose four enables are all 0 never sets its status bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| pin_in | input | 96 | Pin levels from the pads |
| pin_out | output | 96 | Output data to the pads |
| pin_oe | output | 96 | Output enables to the pads |
| irq | output | 1 | Shared interrupt, any status bit set |

## Verification
A status clear written by software can land in the same cycle that a sense event wants to set the same bit. The bench provokes this by holding a high level on an armed input and writing the clear to that pin's status bit. It then reads the bit back and expects it still set. It repeats the clear after the level is removed and the synchroniser has settled, and expects the bit to read 0 with `irq` low. That shows the clear works and the earlier survival came from the live event.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Function group index, taken from bus_addr[7:4]
   typedef enum logic [3:0] {
      GRP_DIR  = 4'd0,
      GRP_POL  = 4'd1,
      GRP_DATA = 4'd2,
      GRP_DSET = 4'd3,
      GRP_DCLR = 4'd4,
      GRP_RISE = 4'd5,
      GRP_FALL = 4'd6,
      GRP_HIGH = 4'd7,
      GRP_LOW  = 4'd8,
      GRP_STAT = 4'd9,
      GRP_EREC = 4'd10
   } grp_e;

   // Per-bank write strobes produced by the decoder
   typedef struct packed {
      logic dir;
      logic pol;
      logic data;
      logic dset;
      logic dclr;
      logic rise;
      logic fall;
      logic high;
      logic low;
      logic stat;
   } bank_wr_t;

   localparam int GRP_LSB  = 4;
   localparam int BANK_LSB = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 8
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output bank_wr_t          wr_strb [NUM_BANKS],
   output logic [3:0]        rd_grp,
   output logic [1:0]        rd_bank,
   output logic              rd_ok
);
   localparam int BANK_FIELD_MAX = 4;

   generate
      if (ADDR_W != 8) begin : g_bad_addr
         $error("gpio_addr_dec expects an 8-bit address");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > BANK_FIELD_MAX) begin : g_bad_banks
         $error("bank count must fit the 2-bit bank field");
      end
   endgenerate

   logic       aligned;
   logic [3:0] grp;
   logic [1:0] bank;
   logic       bank_ok;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign grp     = bus_addr[GRP_LSB +: 4];
   assign bank    = bus_addr[BANK_LSB +: 2];
   assign bank_ok = (int'(bank) < NUM_BANKS);

   assign rd_grp  = grp;
   assign rd_bank = bank;
   assign rd_ok   = bus_sel && aligned && bank_ok;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strb
         logic hit;
         assign hit = bus_sel && bus_we && aligned && (int'(bank) == b);
         always_comb begin
            wr_strb[b]      = '0;
            wr_strb[b].dir  = hit && (grp == GRP_DIR);
            wr_strb[b].pol  = hit && (grp == GRP_POL);
            wr_strb[b].data = hit && (grp == GRP_DATA);
            wr_strb[b].dset = hit && (grp == GRP_DSET);
            wr_strb[b].dclr = hit && (grp == GRP_DCLR);
            wr_strb[b].rise = hit && (grp == GRP_RISE);
            wr_strb[b].fall = hit && (grp == GRP_FALL);
            wr_strb[b].high = hit && (grp == GRP_HIGH);
            wr_strb[b].low  = hit && (grp == GRP_LOW);
            wr_strb[b].stat = hit && (grp == GRP_STAT);
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bank_wr_t     wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_sync,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] dout_q,
   output logic [W-1:0] rise_q,
   output logic [W-1:0] fall_q,
   output logic [W-1:0] high_q,
   output logic [W-1:0] low_q,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] erec_q,
   output logic [W-1:0] data_rd
);
   logic [W-1:0] sense, sense_prev;
   logic [W-1:0] edge_evt, lvl_evt, evt_any, clr_mask;

   assign sense    = pin_sync ^ pol_q;
   assign edge_evt = (sense & ~sense_prev & rise_q) | (~sense & sense_prev & fall_q);
   assign lvl_evt  = (sense & high_q) | (~sense & low_q);
   assign evt_any  = edge_evt | lvl_evt;
   assign clr_mask = wr.stat ? wdata : '0;
   assign data_rd  = (dir_q & dout_q) | (~dir_q & pin_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= '0;
         pol_q      <= '0;
         dout_q     <= '0;
         rise_q     <= '0;
         fall_q     <= '0;
         high_q     <= '0;
         low_q      <= '0;
         stat_q     <= '0;
         erec_q     <= '0;
         sense_prev <= '0;
      end else begin
         sense_prev <= sense;
         if (wr.dir)  dir_q  <= wdata;
         if (wr.pol)  pol_q  <= wdata;
         if (wr.rise) rise_q <= wdata;
         if (wr.fall) fall_q <= wdata;
         if (wr.high) high_q <= wdata;
         if (wr.low)  low_q  <= wdata;
         if (wr.data)      dout_q <= wdata;
         else if (wr.dset) dout_q <= dout_q | wdata;
         else if (wr.dclr) dout_q <= dout_q & ~wdata;
         stat_q <= (stat_q & ~clr_mask) | evt_any;
         erec_q <= (erec_q & ~clr_mask) | edge_evt;
      end
   end

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr.dset) |-> ((dout_q & $past(wdata)) == $past(wdata))); // R4
   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr.dclr) |-> ((dout_q & $past(wdata)) == '0)); // R4
   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr.stat) |-> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
   AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr.stat) |-> ((stat_q & $past(wdata) & ~$past(evt_any)) == '0)); // R8
   AST_EREC_IN_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      ((erec_q & ~stat_q) == '0)); // R9
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int N       = 96,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] stat_all,
   output logic         irq
);
   logic any_set;
   assign any_set = |stat_all;

   generate
      if (IRQ_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_set;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = any_set;
      end
   endgenerate
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
   output logic [NUM_BANKS*BANK_W-1:0] pin_out,
   output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
   output logic                        irq
);
   localparam int NPINS = NUM_BANKS * BANK_W;

   generate
      if (BANK_W != 32) begin : g_bad_width
         $error("bank width must equal the 32-bit bus word");
      end
   endgenerate

   bank_wr_t          wr_strb [NUM_BANKS];
   logic [3:0]        rd_grp;
   logic [1:0]        rd_bank;
   logic              rd_ok;
   logic [NPINS-1:0]  pin_sync;
   logic [NPINS-1:0]  stat_all;
   logic [BANK_W-1:0] rd_word [NUM_BANKS];

   gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .wr_strb (wr_strb),
      .rd_grp  (rd_grp),
      .rd_bank (rd_bank),
      .rd_ok   (rd_ok)
   );

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_sync)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic [BANK_W-1:0] dir_q, pol_q, dout_q, rise_q, fall_q;
         logic [BANK_W-1:0] high_q, low_q, stat_q, erec_q, data_rd;

         gpio_bank_regs #(.W(BANK_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_strb[b]),
            .wdata   (bus_wdata),
            .pin_sync(pin_sync[b*BANK_W +: BANK_W]),
            .dir_q   (dir_q),
            .pol_q   (pol_q),
            .dout_q  (dout_q),
            .rise_q  (rise_q),
            .fall_q  (fall_q),
            .high_q  (high_q),
            .low_q   (low_q),
            .stat_q  (stat_q),
            .erec_q  (erec_q),
            .data_rd (data_rd)
         );

         assign pin_out[b*BANK_W +: BANK_W]  = dout_q;
         assign pin_oe[b*BANK_W +: BANK_W]   = dir_q;
         assign stat_all[b*BANK_W +: BANK_W] = stat_q;

         always_comb begin
            case (rd_grp)
               GRP_DIR:  rd_word[b] = dir_q;
               GRP_POL:  rd_word[b] = pol_q;
               GRP_DATA: rd_word[b] = data_rd;
               GRP_RISE: rd_word[b] = rise_q;
               GRP_FALL: rd_word[b] = fall_q;
               GRP_HIGH: rd_word[b] = high_q;
               GRP_LOW:  rd_word[b] = low_q;
               GRP_STAT: rd_word[b] = stat_q;
               GRP_EREC: rd_word[b] = erec_q;
               default:  rd_word[b] = '0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_ok && (int'(rd_bank) == b)) bus_rdata = rd_word[b];
      end
   end

   gpio_irq_merge #(.N(NPINS), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_all(stat_all),
      .irq     (irq)
   );

   generate
      if (!IRQ_REG) begin : g_irq_chk
         AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq == (stat_all != '0))); // R10
      end
   endgenerate

   AST_OE_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0)); // R1
endmodule

// File: tb/sim_banked_gpio_ctrl.sv
module sim_banked_gpio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [95:0] pin_in = '0;
   logic [95:0] pin_out;
   logic [95:0] pin_oe;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   banked_gpio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  wa;
      logic [31:0] wd;
      logic [7:0]  ra;
      logic [31:0] ex;
   } vec_t;

   // Register map walk: write, then read back (R2, R3, R4)
   localparam vec_t TBL [0:10] = '{
      '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'hFFFF_FFFF},
      '{8'h28, 32'hA5A5_A5A5, 8'h28, 32'hA5A5_A5A5},
      '{8'h38, 32'h0000_000F, 8'h28, 32'hA5A5_A5AF},
      '{8'h48, 32'hA000_0000, 8'h28, 32'h05A5_A5AF},
      '{8'h14, 32'h1234_5678, 8'h14, 32'h1234_5678},
      '{8'h14, 32'h0000_0000, 8'h38, 32'h0000_0000},
      '{8'h54, 32'h0000_0100, 8'h54, 32'h0000_0100},
      '{8'h00, 32'h0000_FFFF, 8'h00, 32'h0000_FFFF},
      '{8'h04, 32'h0000_0000, 8'h00, 32'h0000_FFFF},
      '{8'hA4, 32'hFFFF_FFFF, 8'hA4, 32'h0000_0000},
      '{8'h01, 32'hFFFF_FFFF, 8'h00, 32'h0000_FFFF}
   };

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic waitc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {95'd0, irq}, 96'd0);
      chk("R1 pin_oe", pin_oe, 96'd0);
      for (int g = 0; g < 11; g++) begin
         if (g == 3 || g == 4) continue;
         for (int b = 0; b < 3; b++) begin
            rd(8'((g << 4) | (b << 2)), r);
            chk($sformatf("R1 reg g%0d b%0d", g, b), {64'd0, r}, 96'd0);
         end
      end

      // Table walk
      for (int i = 0; i < 11; i++) begin
         wr(TBL[i].wa, TBL[i].wd);
         rd(TBL[i].ra, r);
         chk($sformatf("R2/R4 table entry %0d", i), {64'd0, r}, {64'd0, TBL[i].ex});
      end
      // R3 outputs on bank 2
      chk("R3 pin_oe", pin_oe, {32'hFFFF_FFFF, 32'd0, 32'h0000_FFFF});
      chk("R3 pin_out bank2", {64'd0, pin_out[95:64]}, {64'd0, 32'h05A5_A5AF});

      // R6 rising edge on global pin 40 (bank1 bit8), exact latency
      @(negedge clk) pin_in[40] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R6 latency not yet", {95'd0, irq}, 96'd0);
      @(posedge clk); @(negedge clk);
      chk("R6 R10 irq after edge", {95'd0, irq}, 96'd1);
      rd(8'h94, r); chk("R6 R2 status bank1", {64'd0, r}, {64'd0, 32'h100});
      rd(8'hA4, r); chk("R9 edge record", {64'd0, r}, {64'd0, 32'h100});

      // R8 zero bits leave status; one bit clears
      wr(8'h94, 32'hFFFF_FEFF);
      rd(8'h94, r); chk("R8 write0 keeps", {64'd0, r}, {64'd0, 32'h100});
      wr(8'h94, 32'h0000_0100);
      rd(8'h94, r); chk("R8 w1c clears", {64'd0, r}, 96'd0);
      rd(8'hA4, r); chk("R9 record cleared", {64'd0, r}, 96'd0);
      chk("R10 irq low", {95'd0, irq}, 96'd0);
      waitc(4);
      rd(8'h94, r); chk("R6 edge not repeated", {64'd0, r}, 96'd0);

      // R6 falling added to rising enable on same pin
      wr(8'h64, 32'h0000_0100);
      @(negedge clk) pin_in[40] = 1'b0;
      waitc(4);
      rd(8'h94, r); chk("R6 falling edge", {64'd0, r}, {64'd0, 32'h100});
      wr(8'h94, 32'h0000_0100);

      // R3 input data read on global pin 20 (bank0 bit20)
      @(negedge clk) pin_in[20] = 1'b1;
      waitc(2);
      rd(8'h20, r); chk("R3 input read", {64'd0, r}, {64'd0, 32'h0010_0000});

      // R7/R8 level high held while clearing
      wr(8'h70, 32'h0010_0000);
      waitc(1);
      rd(8'h90, r); chk("R7 high level", {64'd0, r}, {64'd0, 32'h0010_0000});
      rd(8'hA0, r); chk("R9 level no record", {64'd0, r}, 96'd0);
      wr(8'h90, 32'h0010_0000);
      rd(8'h90, r); chk("R8 R7 clear vs live level", {64'd0, r}, {64'd0, 32'h0010_0000});
      @(negedge clk) pin_in[20] = 1'b0;
      waitc(4);
      wr(8'h90, 32'h0010_0000);
      rd(8'h90, r); chk("R8 clear after level gone", {64'd0, r}, 96'd0);
      chk("R10 irq after clear", {95'd0, irq}, 96'd0);
      wr(8'h70, 32'h0);

      // R5 polarity with low level on global pin 35 (bank1 bit3)
      wr(8'h84, 32'h0000_0008);
      waitc(1);
      rd(8'h94, r); chk("R7 low level", {64'd0, r}, {64'd0, 32'h8});
      wr(8'h14, 32'h0000_0008);
      wr(8'h94, 32'h0000_0008);
      waitc(1);
      rd(8'h94, r); chk("R5 inverted low idle", {64'd0, r}, 96'd0);
      @(negedge clk) pin_in[35] = 1'b1;
      waitc(4);
      rd(8'h94, r); chk("R5 inverted high senses low", {64'd0, r}, {64'd0, 32'h8});
      wr(8'h84, 32'h0);
      wr(8'h94, 32'h0000_0008);

      // R11 masked pin 41 toggling
      @(negedge clk) pin_in[41] = 1'b1;
      waitc(4);
      @(negedge clk) pin_in[41] = 1'b0;
      waitc(4);
      rd(8'h94, r); chk("R11 masked pin", {64'd0, r}, 96'd0);
      chk("R11 irq", {95'd0, irq}, 96'd0);

      // R10 R2 bank2 pin 70 (bit6)
      wr(8'h58, 32'h0000_0040);
      @(negedge clk) pin_in[70] = 1'b1;
      waitc(4);
      rd(8'h98, r); chk("R2 bank2 status", {64'd0, r}, {64'd0, 32'h40});
      chk("R10 irq bank2", {95'd0, irq}, 96'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule